// File: doc/BRIEF.md
# Mode-Space Orbit Feedback Controller

This block turns one vector of beam-position readings into kick settings for the few corrector magnets of one cell. It first forms the orbit error by subtracting a stored reference orbit. It then projects that error onto the singular-value eigenmodes through a stored transposed left-singular matrix. Each mode is scaled by its own inverse singular-value weight and regulated by its own proportional-integral controller. The regulated mode vector is then mapped back to the local correctors through a stored rows-of-V submatrix. The sizes are parameters: N position readings, K modes (K may be smaller than N) and M local correctors.

The arithmetic runs in sequence on one shared multiplier and one accumulator, with one multiply-accumulate per cycle. The orbit sample enters on a valid/ready handshake. `in_ready` is high only while the block is idle. Once a result is presented, `out_valid` stays high and the kick outputs stay frozen until `out_ready` is seen high on a clock edge. No new sample is accepted before that, so a stalled consumer stalls the producer. All coefficients arrive through a plain write port. A write that arrives during a computation is held and applied once that computation is over. An enable pin switches the loop on and off.

Top module: `ofb_modal_ctrl`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. Every coefficient is zero, so a first sample yields all-zero kicks.
- R2: A sample is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` then stays 0 until the result is taken. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `kick_o` does not change. When `out_ready` is seen at an edge, the block returns to idle.
- R3: `out_valid` first reads 1 exactly K*N + 3*K + M*K clock edges after the accepting edge (27 for N=4, K=3, M=2).
- R4: Mode k before weighting is floor(sum over i of UT[k][i]*(x_i - g_i) / 2^FRAC). Here x_i is reading i, taken as a signed DW-bit field at bits [i*DW +: DW] of `orbit_i`, and g_i is the stored golden value.
- R5: The weighted mode is w_k = floor(p_k * S[k] / 2^FRAC).
- R6: Each mode has its own integrator. On every computation with the loop on, it does integ_k += floor(w_k*KI[k]/2^FRAC). The mode output is floor(w_k*KP[k]/2^FRAC) + integ_k, using the updated integrator. Integrators persist from one sample to the next.
- R7: Kick j is floor(sum over k of V[j][k]*u_k / 2^FRAC). It is presented as a signed OW-bit field at bits [j*OW +: OW] of `kick_o`.
- R8: A kick beyond the signed OW-bit range saturates to 2^(OW-1)-1 or -2^(OW-1).
- R9: A coefficient entry that was never written reads as zero, so unconfigured modes and rows contribute nothing. A write whose address is at or beyond the depth of the selected table, or whose select code is 6 or 7, changes nothing.
- R10: While `loop_on` is 0, every integrator is held at zero. A sample accepted while `loop_on` is 0 produces all-zero kicks. After re-enabling, integration restarts from zero.
- R11: A coefficient write issued during a computation does not affect that computation's result. It takes effect before the next sample is processed. If several writes arrive during one computation, the last one is kept.
- R12: Coefficients are signed with FRAC fractional bits. They are selected by `cfg_sel`: 0 golden (address i, low DW bits of data), 1 UT (address k*N+i), 2 mode weight (address k), 3 proportional gain (address k), 4 integral gain (address k), 5 V (address j*K+k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| loop_on | input | 1 | Feedback loop enable |
| in_valid | input | 1 | Orbit sample valid |
| in_ready | output | 1 | Block idle and ready for a sample |
| orbit_i | input | N*DW | Packed signed position readings |
| out_valid | output | 1 | Kick result valid |
| out_ready | input | 1 | Consumer takes the kick result |
| kick_o | output | M*OW | Packed signed corrector kicks |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 3 | Coefficient table select |
| cfg_addr | input | CFG_AW | Entry address within the table |
| cfg_data | input | CW | Signed coefficient value |

## Verification
Two functions can fall in the same cycle: a coefficient write, and the sequenced arithmetic that reads the same table. The bench provokes this by writing a new golden value one edge after a sample has been accepted. It expects that result to match a prediction made with the old value, and the following sample to match the new one. The second overlap is between turning the loop off and the integrator update. It is judged by turning the loop off between samples with a non-zero integrator, then checking for zero kicks and for integration starting over once the loop is back on.

// File: rtl/ofb_pkg.sv
package ofb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROJ,
    ST_WGT,
    ST_PINT,
    ST_PPROP,
    ST_BACK,
    ST_HOLD
  } ofb_state_e;

  localparam logic [2:0] SEL_GOLD = 3'd0;
  localparam logic [2:0] SEL_UT   = 3'd1;
  localparam logic [2:0] SEL_WGT  = 3'd2;
  localparam logic [2:0] SEL_KP   = 3'd3;
  localparam logic [2:0] SEL_KI   = 3'd4;
  localparam logic [2:0] SEL_V    = 3'd5;

  function automatic int idx_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/ofb_coef_bank.sv
module ofb_coef_bank
  import ofb_pkg::*;
#(
  parameter int N      = 4,
  parameter int K      = 3,
  parameter int M      = 2,
  parameter int DW     = 16,
  parameter int CW     = 18,
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply_ok,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CW-1:0]     cfg_data,
  input  logic [idx_bits(N)-1:0] bpm_idx,
  input  logic [idx_bits(K)-1:0] mode_idx,
  input  logic [idx_bits(M)-1:0] kick_idx,
  output logic [DW-1:0]     gold_o,
  output logic [CW-1:0]     ut_o,
  output logic [CW-1:0]     sw_o,
  output logic [CW-1:0]     kp_o,
  output logic [CW-1:0]     ki_o,
  output logic [CW-1:0]     v_o
);
  localparam int NB  = idx_bits(N);
  localparam int KB  = idx_bits(K);
  localparam int UTB = idx_bits(K*N);
  localparam int VB  = idx_bits(M*K);

  logic [N-1:0][DW-1:0]   gold_q;
  logic [K*N-1:0][CW-1:0] ut_q;
  logic [K-1:0][CW-1:0]   sw_q, kp_q, ki_q;
  logic [M*K-1:0][CW-1:0] v_q;

  logic              pend_v;
  logic [2:0]        pend_sel;
  logic [CFG_AW-1:0] pend_addr;
  logic [CW-1:0]     pend_data;

  logic              wr_v;
  logic [2:0]        wr_sel;
  int                wr_a;
  logic [CW-1:0]     wr_data;

  always_comb begin
    wr_v    = 1'b0;
    wr_sel  = pend_sel;
    wr_a    = int'(pend_addr);
    wr_data = pend_data;
    if (apply_ok && pend_v) begin
      wr_v = 1'b1;
    end else if (apply_ok && cfg_we) begin
      wr_v    = 1'b1;
      wr_sel  = cfg_sel;
      wr_a    = int'(cfg_addr);
      wr_data = cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_sel  <= '0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (cfg_we && !(apply_ok && !pend_v)) begin
      pend_v    <= 1'b1;
      pend_sel  <= cfg_sel;
      pend_addr <= cfg_addr;
      pend_data <= cfg_data;
    end else if (apply_ok && pend_v) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gold_q <= '0;
      ut_q   <= '0;
      sw_q   <= '0;
      kp_q   <= '0;
      ki_q   <= '0;
      v_q    <= '0;
    end else if (wr_v) begin
      case (wr_sel)
        SEL_GOLD: if (wr_a < N)   gold_q[NB'(wr_a)] <= wr_data[DW-1:0];
        SEL_UT:   if (wr_a < K*N) ut_q[UTB'(wr_a)]  <= wr_data;
        SEL_WGT:  if (wr_a < K)   sw_q[KB'(wr_a)]   <= wr_data;
        SEL_KP:   if (wr_a < K)   kp_q[KB'(wr_a)]   <= wr_data;
        SEL_KI:   if (wr_a < K)   ki_q[KB'(wr_a)]   <= wr_data;
        SEL_V:    if (wr_a < M*K) v_q[VB'(wr_a)]    <= wr_data;
        default: ;
      endcase
    end
  end

  logic [UTB-1:0] ut_ra;
  logic [VB-1:0]  v_ra;
  assign ut_ra = UTB'(int'(mode_idx) * N + int'(bpm_idx));
  assign v_ra  = VB'(int'(kick_idx) * K + int'(mode_idx));

  assign gold_o = gold_q[bpm_idx];
  assign ut_o   = ut_q[ut_ra];
  assign sw_o   = sw_q[mode_idx];
  assign kp_o   = kp_q[mode_idx];
  assign ki_o   = ki_q[mode_idx];
  assign v_o    = v_q[v_ra];

  // R11
  store_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_ok |=> $stable({gold_q, ut_q, sw_q, kp_q, ki_q, v_q}));

endmodule

// File: rtl/ofb_mac.sv
module ofb_mac #(
  parameter int IW = 32,
  parameter int CW = 18,
  parameter int AW = 53
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first,
  input  logic signed [IW-1:0] a,
  input  logic signed [CW-1:0] b,
  output logic signed [AW-1:0] sum_o
);
  logic signed [IW+CW-1:0] prod;
  logic signed [AW-1:0]    acc_q;

  assign prod  = a * b;
  assign sum_o = (first ? '0 : acc_q) + AW'(prod);

  always_ff @(posedge clk) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= sum_o;
  end
endmodule

// File: rtl/ofb_modal_ctrl.sv
module ofb_modal_ctrl
  import ofb_pkg::*;
#(
  parameter int N      = 4,
  parameter int K      = 3,
  parameter int M      = 2,
  parameter int DW     = 16,
  parameter int CW     = 18,
  parameter int FRAC   = 12,
  parameter int IW     = 32,
  parameter int OW     = 18,
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_on,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N*DW-1:0]   orbit_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [M*OW-1:0]   kick_o,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CW-1:0]     cfg_data
);
  localparam int NB = idx_bits(N);
  localparam int KB = idx_bits(K);
  localparam int MB = idx_bits(M);
  localparam int AW = IW + CW + idx_bits((N > K) ? N : K) + 1;
  localparam longint OMAX_L = (longint'(1) << (OW - 1)) - 1;
  localparam longint OMIN_L = -(longint'(1) << (OW - 1));
  localparam logic signed [AW-1:0] OMAX_A = AW'(OMAX_L);
  localparam logic signed [AW-1:0] OMIN_A = AW'(OMIN_L);

  ofb_state_e state_q;
  logic [NB-1:0] i_q;
  logic [KB-1:0] k_q;
  logic [MB-1:0] j_q;
  logic          on_q;
  logic [N-1:0][DW-1:0] orb_q;
  logic [K-1:0][IW-1:0] mode_q;
  logic [K-1:0][IW-1:0] integ_q;
  logic [M-1:0][OW-1:0] kick_q;

  logic [DW-1:0] gold_w;
  logic [CW-1:0] ut_w, sw_w, kp_w, ki_w, v_w;
  logic apply_ok;

  assign apply_ok  = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);

  ofb_coef_bank #(.N(N), .K(K), .M(M), .DW(DW), .CW(CW), .CFG_AW(CFG_AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .apply_ok(apply_ok),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .bpm_idx(i_q), .mode_idx(k_q), .kick_idx(j_q),
    .gold_o(gold_w), .ut_o(ut_w), .sw_o(sw_w), .kp_o(kp_w), .ki_o(ki_w), .v_o(v_w)
  );

  // operand selection for the shared multiplier
  logic signed [DW:0]    err;
  logic signed [IW-1:0]  mac_a;
  logic signed [CW-1:0]  mac_b;
  logic signed [AW-1:0]  sum;
  logic signed [AW-1:0]  scaled;
  logic signed [IW-1:0]  scaled_iw;
  logic                  mac_en, mac_first;
  logic [OW-1:0]         sat_v;

  assign err = $signed({orb_q[i_q][DW-1], orb_q[i_q]}) - $signed({gold_w[DW-1], gold_w});

  always_comb begin
    mac_a     = $signed(mode_q[k_q]);
    mac_b     = $signed(v_w);
    mac_first = 1'b1;
    mac_en    = 1'b1;
    case (state_q)
      ST_PROJ:  begin mac_a = IW'(err); mac_b = $signed(ut_w); mac_first = (i_q == '0); end
      ST_WGT:   mac_b = $signed(sw_w);
      ST_PINT:  mac_b = $signed(ki_w);
      ST_PPROP: mac_b = $signed(kp_w);
      ST_BACK:  mac_first = (k_q == '0);
      default:  mac_en = 1'b0;
    endcase
  end

  ofb_mac #(.IW(IW), .CW(CW), .AW(AW)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(mac_en), .first(mac_first),
    .a(mac_a), .b(mac_b), .sum_o(sum)
  );

  assign scaled    = sum >>> FRAC;
  assign scaled_iw = scaled[IW-1:0];
  assign sat_v     = (scaled > OMAX_A) ? OW'(OMAX_L) :
                     (scaled < OMIN_A) ? OW'(OMIN_L) : scaled[OW-1:0];

  logic last_i, last_k, last_j;
  assign last_i = (i_q == NB'(N - 1));
  assign last_k = (k_q == KB'(K - 1));
  assign last_j = (j_q == MB'(M - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      i_q     <= '0;
      k_q     <= '0;
      j_q     <= '0;
      on_q    <= 1'b0;
      orb_q   <= '0;
      mode_q  <= '0;
      integ_q <= '0;
      kick_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid) begin
          orb_q   <= orbit_i;
          on_q    <= loop_on;
          i_q     <= '0;
          k_q     <= '0;
          j_q     <= '0;
          state_q <= ST_PROJ;
        end
        ST_PROJ: begin
          if (last_i) begin
            mode_q[k_q] <= scaled_iw;
            i_q         <= '0;
            k_q         <= last_k ? '0 : k_q + 1'b1;
            if (last_k) state_q <= ST_WGT;
          end else begin
            i_q <= i_q + 1'b1;
          end
        end
        ST_WGT, ST_PINT, ST_PPROP: begin
          if (state_q == ST_WGT) mode_q[k_q] <= scaled_iw;
          if (state_q == ST_PINT && on_q) integ_q[k_q] <= $signed(integ_q[k_q]) + scaled_iw;
          if (state_q == ST_PPROP) mode_q[k_q] <= scaled_iw + $signed(integ_q[k_q]);
          k_q <= last_k ? '0 : k_q + 1'b1;
          if (last_k) begin
            state_q <= (state_q == ST_WGT)  ? ST_PINT :
                       (state_q == ST_PINT) ? ST_PPROP : ST_BACK;
          end
        end
        ST_BACK: begin
          if (last_k) begin
            kick_q[j_q] <= on_q ? sat_v : '0;
            k_q         <= '0;
            j_q         <= last_j ? '0 : j_q + 1'b1;
            if (last_j) state_q <= ST_HOLD;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
      if (!loop_on) integ_q <= '0;
    end
  end

  for (genvar g = 0; g < M; g++) begin : g_kick
    assign kick_o[g*OW +: OW] = kick_q[g];
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(kick_o));

  // R2
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R10
  integ_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_on |=> (integ_q == '0));

  // R10
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && !on_q |-> (kick_o == '0));

endmodule

// File: tb/test_ofb_modal_ctrl.sv
module test_ofb_modal_ctrl;
  localparam int CLK_P = 10;
  localparam int N = 4, K = 3, M = 2, DW = 16, CW = 18, FRAC = 12, OW = 18, CFG_AW = 8;
  localparam int LAT = K*N + 3*K + M*K;

  logic clk = 0, rst_n = 0, loop_on = 0, in_valid = 0, out_ready = 0, cfg_we = 0;
  logic in_ready, out_valid;
  logic [N*DW-1:0] orbit_i = '0;
  logic [M*OW-1:0] kick_o;
  logic [2:0] cfg_sel = '0;
  logic [CFG_AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_data = '0;

  int total = 0, bad = 0;
  longint g[N], ut[K*N], sw[K], kp[K], ki[K], v[M*K], integ[K];
  bit on_m = 0;

  ofb_modal_ctrl #(.N(N), .K(K), .M(M), .DW(DW), .CW(CW), .FRAC(FRAC), .OW(OW), .CFG_AW(CFG_AW))
  i_ofb_modal_ctrl (
    .clk(clk), .rst_n(rst_n), .loop_on(loop_on), .in_valid(in_valid), .in_ready(in_ready),
    .orbit_i(orbit_i), .out_valid(out_valid), .out_ready(out_ready), .kick_o(kick_o),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint kick_at(input int j);
    return longint'($signed(kick_o[j*OW +: OW]));
  endfunction

  // R12 encodings; R9 out-of-range and unused codes leave the model unchanged
  task automatic cfg_write(input int sel, input int addr, input longint val, input bit upd);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = 3'(sel); cfg_addr = CFG_AW'(addr); cfg_data = CW'(val);
    @(posedge clk); #1;
    cfg_we = 0;
    if (upd) begin
      case (sel)
        0: if (addr < N)   g[addr]  = val;
        1: if (addr < K*N) ut[addr] = val;
        2: if (addr < K)   sw[addr] = val;
        3: if (addr < K)   kp[addr] = val;
        4: if (addr < K)   ki[addr] = val;
        5: if (addr < M*K) v[addr]  = val;
        default: ;
      endcase
    end
  endtask

  task automatic set_loop(input bit on);
    @(posedge clk); #1;
    loop_on = on; on_m = on;
    if (!on) for (int k = 0; k < K; k++) integ[k] = 0;
  endtask

  task automatic predict(input longint x[N], output longint ek[M]);
    longint p, w, u[K], s;
    for (int k = 0; k < K; k++) begin
      s = 0;
      for (int i = 0; i < N; i++) s += ut[k*N+i] * (x[i] - g[i]);
      p = s >>> FRAC;
      w = (p * sw[k]) >>> FRAC;
      if (on_m) integ[k] += (w * ki[k]) >>> FRAC;
      u[k] = ((w * kp[k]) >>> FRAC) + integ[k];
    end
    for (int j = 0; j < M; j++) begin
      s = 0;
      for (int k = 0; k < K; k++) s += v[j*K+k] * u[k];
      s = s >>> FRAC;
      if (s > 131071) s = 131071;
      if (s < -131072) s = -131072;
      ek[j] = on_m ? s : 0;
    end
  endtask

  task automatic run_sample(input longint x[N], input int hold, input bit busy_wr,
                            input longint new_g0, input string req);
    longint ek[M];
    logic [M*OW-1:0] snap;
    int c;
    predict(x, ek);
    @(negedge clk);
    chk("R2", "in_ready idle", longint'(in_ready), 1);
    @(posedge clk); #1;
    in_valid = 1;
    for (int i = 0; i < N; i++) orbit_i[i*DW +: DW] = DW'(x[i]);
    @(posedge clk); #1;
    in_valid = 0;
    c = 0;
    if (busy_wr) begin
      cfg_we = 1; cfg_sel = 3'd0; cfg_addr = '0; cfg_data = CW'(new_g0);
      @(posedge clk); #1;
      cfg_we = 0; c = 1;
    end
    while (c < 200) begin
      @(posedge clk); c++;
      @(negedge clk);
      if (out_valid) break;
    end
    chk("R3", "latency", c, LAT);
    for (int j = 0; j < M; j++) chk(req, $sformatf("kick%0d", j), kick_at(j), ek[j]);
    snap = kick_o;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); @(negedge clk);
      chk("R2", "valid held", longint'(out_valid), 1);
      chk("R2", "kick stable", longint'(kick_o == snap), 1);
      chk("R2", "no accept while held", longint'(in_ready), 0);
    end
    @(posedge clk); #1; out_ready = 1;
    @(posedge clk); #1; out_ready = 0;
    @(negedge clk);
    chk("R2", "released", longint'(out_valid), 0);
  endtask

  task automatic test_reset();
    longint x[N] = '{500, -200, 300, 100};
    @(negedge clk);
    chk("R1", "in_ready", longint'(in_ready), 1);
    chk("R1", "out_valid", longint'(out_valid), 0);
    set_loop(1);
    run_sample(x, 0, 0, 0, "R1");
  endtask

  task automatic test_basic();
    longint x1[N] = '{1200, -800, 400, 2000};
    longint x2[N] = '{-1500, 300, 900, -600};
    for (int i = 0; i < N; i++) cfg_write(0, i, 100*i - 150, 1);
    for (int k = 0; k < K; k++)
      for (int i = 0; i < N; i++) cfg_write(1, k*N+i, (k+1)*1000 - i*700, 1);
    cfg_write(2, 0, 4096, 1);   // mode 2 weight left zero: padding, R9
    cfg_write(2, 1, 6144, 1);
    for (int k = 0; k < K; k++) cfg_write(3, k, 8192, 1);
    for (int k = 0; k < K; k++) begin
      cfg_write(5, k, 2000 + 300*k, 1);
      cfg_write(5, K + k, -1500 + 500*k, 1);
    end
    run_sample(x1, 4, 0, 0, "R4 R5 R7");
    run_sample(x2, 0, 0, 0, "R4 R5 R7 R9");
  endtask

  task automatic test_integral();
    longint x[N] = '{900, -400, 700, 1500};
    for (int k = 0; k < K; k++) cfg_write(4, k, 2048, 1);
    for (int r = 0; r < 3; r++) run_sample(x, 0, 0, 0, "R6");
  endtask

  task automatic test_busy_write();
    longint x[N] = '{1000, 200, -300, 800};
    run_sample(x, 0, 1, 700, "R11 old value");
    g[0] = 700;
    run_sample(x, 0, 0, 0, "R11 new value");
  endtask

  task automatic test_ignored();
    longint x[N] = '{-700, 1100, 250, -50};
    cfg_write(0, N, 999, 1);
    cfg_write(1, K*N, 999, 1);
    cfg_write(5, M*K, 999, 1);
    cfg_write(7, 0, 999, 1);
    cfg_write(6, 1, 999, 1);
    run_sample(x, 0, 0, 0, "R9 ignored writes");
  endtask

  task automatic test_loop_off();
    longint x[N] = '{900, -400, 700, 1500};
    set_loop(0);
    run_sample(x, 0, 0, 0, "R10 off zero");
    set_loop(1);
    run_sample(x, 0, 0, 0, "R10 restart");
  endtask

  task automatic test_saturation();
    longint xp[N] = '{3000, 3000, 3000, 3000};
    longint xn[N] = '{-3000, -3000, -3000, -3000};
    for (int i = 0; i < N; i++) cfg_write(0, i, 0, 1);
    for (int a = 0; a < K*N; a++) cfg_write(1, a, 4096, 1);
    for (int k = 0; k < K; k++) begin
      cfg_write(3, k, 32768, 1);
      cfg_write(4, k, 0, 1);
    end
    for (int a = 0; a < M*K; a++) cfg_write(5, a, 30000, 1);
    run_sample(xp, 0, 0, 0, "R8 positive");
    chk("R8", "positive clamp", kick_at(0), 131071);
    run_sample(xn, 0, 0, 0, "R8 negative");
    chk("R8", "negative clamp", kick_at(0), -131072);
  endtask

  initial begin
    for (int i = 0; i < N; i++) g[i] = 0;
    for (int a = 0; a < K*N; a++) ut[a] = 0;
    for (int k = 0; k < K; k++) begin sw[k] = 0; kp[k] = 0; ki[k] = 0; integ[k] = 0; end
    for (int a = 0; a < M*K; a++) v[a] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    test_reset();
    test_basic();
    test_integral();
    test_busy_write();
    test_ignored();
    test_loop_off();
    test_saturation();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule